// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Unit

This block resolves data hazards in a five-stage in-order integer pipeline with fetch, decode, execute, memory and writeback stages. It compares the source register numbers of the instruction in execute against the destination registers held in the two later pipeline latches. From that comparison it produces a 2-bit bypass select for each ALU operand, so that the newest in-flight result reaches the ALU without waiting for the register file.

It also watches the decode stage. If a load that is still in execute writes a register that the decoding instruction needs, forwarding cannot help. The block then freezes the PC and the decode latch and injects a bubble into execute, while the load moves on. A third output pair flags when the register file must pass a same-cycle write straight through to a decode-stage read.

Every output is purely combinational and the block holds no state. Register 0 is hardwired to zero, so it never matches. Each source field carries a valid bit, which stops unused operand fields from causing false bypasses or stalls.

Top module: `hz_unit`

## Requirements
- R1: `fwd_a` is 1 (take the memory-stage result) when `mem_we` is 1, `mem_rd` is nonzero, `ex_rs1_vld` is 1 and `mem_rd` equals `ex_rs1`.
- R2: `fwd_b` follows the same rule as R1, using `ex_rs2` and `ex_rs2_vld`.
- R3: An operand select is 2 (take the writeback-stage result) when `wb_we` is 1, `wb_rd` is nonzero, the source is valid, `wb_rd` equals that source, and the memory stage does not match the same source.
- R4: When the memory stage and the writeback stage both match the same source, the select is 1, because the newer value wins.
- R5: An operand select is 0 (register file value) when neither later stage matches. A source or destination number of 0 never matches. A select value of 3 is never produced.
- R6: A source whose valid bit is 0 never causes a bypass, a stall or an internal-bypass flag.
- R7: A stall occurs exactly when `idex_is_load` and `idex_we` are both 1, `idex_rd` is nonzero, and `idex_rd` equals a valid decode-stage source (`id_rs1` or `id_rs2`).
- R8: During a stall, `pc_en` is 0, `ifid_en` is 0 and `bubble` is 1. Otherwise `pc_en` is 1, `ifid_en` is 1 and `bubble` is 0.
- R9: `rf_byp_a` (`rf_byp_b`) is 1 exactly when `wb_we` is 1, `wb_rd` is nonzero, and `wb_rd` equals a valid `id_rs1` (`id_rs2`).
- R10: All outputs settle within the same cycle as their inputs, with no register on any path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | Execute-stage first source register |
| ex_rs1_vld | input | 1 | Execute-stage first source is read |
| ex_rs2 | input | 5 | Execute-stage second source register |
| ex_rs2_vld | input | 1 | Execute-stage second source is read |
| mem_we | input | 1 | Memory-stage latch writes a register |
| mem_rd | input | 5 | Memory-stage latch destination |
| wb_we | input | 1 | Writeback-stage latch writes a register |
| wb_rd | input | 5 | Writeback-stage latch destination |
| id_rs1 | input | 5 | Decode-stage first source register |
| id_rs1_vld | input | 1 | Decode-stage first source is read |
| id_rs2 | input | 5 | Decode-stage second source register |
| id_rs2_vld | input | 1 | Decode-stage second source is read |
| idex_is_load | input | 1 | Instruction in execute is a load |
| idex_we | input | 1 | Instruction in execute writes a register |
| idex_rd | input | 5 | Destination of the instruction in execute |
| fwd_a | output | 2 | Operand A select: 0 register file, 1 memory stage, 2 writeback stage |
| fwd_b | output | 2 | Operand B select, same encoding |
| pc_en | output | 1 | PC update enable |
| ifid_en | output | 1 | Decode latch load enable |
| bubble | output | 1 | Clear the controls entering execute |
| rf_byp_a | output | 1 | Register file must pass the write through to decode source 1 |
| rf_byp_b | output | 1 | Register file must pass the write through to decode source 2 |

## Verification
The hardest situation to reach is a collision where both later stages name the same nonzero register as one execute source. Within the same vector, the other source matches only the older stage, or is masked by its valid bit. Uniform random register numbers over 32 values almost never line up like that. The stimulus therefore draws register numbers from a narrow range that includes 0, and adds directed vectors that build the double match, the masked match and the register-0 match on purpose. Each vector is compared against a behavioural model in the bench.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int IDX_W  = 5;
    localparam int N_OPS  = 2;
    localparam int SEL_W  = 2;

    typedef logic [IDX_W-1:0] ridx_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_RF  = 2'd0,
        SEL_MEM = 2'd1,
        SEL_WB  = 2'd2
    } fwd_sel_e;

    typedef struct packed {
        logic  vld;
        ridx_t idx;
    } src_t;

    typedef struct packed {
        logic  we;
        ridx_t idx;
    } dst_t;

    function automatic logic dst_hits(input dst_t d, input src_t s);
        return d.we && s.vld && (d.idx != '0) && (d.idx == s.idx);
    endfunction

endpackage

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
    import hz_pkg::*;
(
    input  src_t     src,
    input  dst_t     mem_dst,
    input  dst_t     wb_dst,
    output fwd_sel_e sel
);
    logic mem_hit;
    logic wb_hit;

    assign mem_hit = dst_hits(mem_dst, src);
    assign wb_hit  = dst_hits(wb_dst, src);

    always_comb begin
        if (mem_hit)      sel = SEL_MEM;
        else if (wb_hit)  sel = SEL_WB;
        else              sel = SEL_RF;
    end

    always_comb begin
        // R4: the writeback path is chosen only when the memory stage misses this source
        a_r4_newer_wins: assert (!(sel == SEL_WB && mem_dst.we && src.vld &&
                                   mem_dst.idx == src.idx && mem_dst.idx != '0));
        // R6: a masked source always reads the register file
        a_r6_masked_rf: assert (src.vld || sel == SEL_RF);
        // R5: register 0 is never bypassed
        a_r5_zero_rf: assert (src.idx != '0 || sel == SEL_RF);
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hz_pkg::*;
(
    input  src_t id_src [N_OPS],
    input  logic ld,
    input  dst_t ld_dst,
    output logic stall
);
    logic [N_OPS-1:0] hit;
    dst_t             ld_eff;

    assign ld_eff.we  = ld_dst.we & ld;
    assign ld_eff.idx = ld_dst.idx;

    for (genvar g = 0; g < N_OPS; g++) begin : g_src
        assign hit[g] = dst_hits(ld_eff, id_src[g]);
    end

    assign stall = |hit;

    always_comb begin
        // R7: only a load that writes can hold the front end
        a_r7_load_only: assert (!stall || (ld && ld_dst.we && ld_dst.idx != '0));
    end
endmodule

// File: rtl/hz_rf_byp.sv
module hz_rf_byp
    import hz_pkg::*;
(
    input  src_t             id_src [N_OPS],
    input  dst_t             wb_dst,
    output logic [N_OPS-1:0] pass
);
    for (genvar g = 0; g < N_OPS; g++) begin : g_src
        assign pass[g] = dst_hits(wb_dst, id_src[g]);
    end

    always_comb begin
        // R9: no pass-through without a live writeback
        a_r9_needs_write: assert (pass == '0 || (wb_dst.we && wb_dst.idx != '0));
    end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
(
    input  logic [4:0] ex_rs1,
    input  logic       ex_rs1_vld,
    input  logic [4:0] ex_rs2,
    input  logic       ex_rs2_vld,
    input  logic       mem_we,
    input  logic [4:0] mem_rd,
    input  logic       wb_we,
    input  logic [4:0] wb_rd,
    input  logic [4:0] id_rs1,
    input  logic       id_rs1_vld,
    input  logic [4:0] id_rs2,
    input  logic       id_rs2_vld,
    input  logic       idex_is_load,
    input  logic       idex_we,
    input  logic [4:0] idex_rd,
    output logic [1:0] fwd_a,
    output logic [1:0] fwd_b,
    output logic       pc_en,
    output logic       ifid_en,
    output logic       bubble,
    output logic       rf_byp_a,
    output logic       rf_byp_b
);
    src_t             ex_src [N_OPS];
    src_t             id_src [N_OPS];
    dst_t             mem_dst;
    dst_t             wb_dst;
    dst_t             ld_dst;
    fwd_sel_e         sel    [N_OPS];
    logic [N_OPS-1:0] pass;
    logic             stall;

    assign ex_src[0] = '{vld: ex_rs1_vld, idx: ex_rs1};
    assign ex_src[1] = '{vld: ex_rs2_vld, idx: ex_rs2};
    assign id_src[0] = '{vld: id_rs1_vld, idx: id_rs1};
    assign id_src[1] = '{vld: id_rs2_vld, idx: id_rs2};
    assign mem_dst   = '{we: mem_we, idx: mem_rd};
    assign wb_dst    = '{we: wb_we,  idx: wb_rd};
    assign ld_dst    = '{we: idex_we, idx: idex_rd};

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        hz_opnd_sel u_sel (
            .src     (ex_src[g]),
            .mem_dst (mem_dst),
            .wb_dst  (wb_dst),
            .sel     (sel[g])
        );
    end

    hz_load_use u_lu (
        .id_src (id_src),
        .ld     (idex_is_load),
        .ld_dst (ld_dst),
        .stall  (stall)
    );

    hz_rf_byp u_rfb (
        .id_src (id_src),
        .wb_dst (wb_dst),
        .pass   (pass)
    );

    assign fwd_a    = sel[0];
    assign fwd_b    = sel[1];
    assign pc_en    = ~stall;
    assign ifid_en  = ~stall;
    assign bubble   = stall;
    assign rf_byp_a = pass[0];
    assign rf_byp_b = pass[1];

    always_comb begin
        // R8: front-end hold and bubble always move together
        a_r8_hold_bubble: assert ((pc_en == ifid_en) && (bubble == ~pc_en));
        // R5: the unused select code never appears
        a_r5_no_code3: assert (fwd_a != 2'd3 && fwd_b != 2'd3);
    end
endmodule

// File: tb/hz_unit_tb.sv
module hz_unit_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [4:0] ex_rs1, ex_rs2, mem_rd, wb_rd, id_rs1, id_rs2, idex_rd;
    logic ex_rs1_vld, ex_rs2_vld, mem_we, wb_we, id_rs1_vld, id_rs2_vld;
    logic idex_is_load, idex_we;
    logic [1:0] fwd_a, fwd_b;
    logic pc_en, ifid_en, bubble, rf_byp_a, rf_byp_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    hz_unit u_dut (.*);

    function automatic logic live(input logic we, input logic [4:0] d,
                                  input logic v, input logic [4:0] s);
        if (!we || !v) return 1'b0;
        if (d == 5'd0) return 1'b0;
        return d == s;
    endfunction

    function automatic logic [1:0] ref_sel(input logic v, input logic [4:0] s);
        if (live(mem_we, mem_rd, v, s)) return 2'd1;
        if (live(wb_we, wb_rd, v, s))   return 2'd2;
        return 2'd0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string ctx);
        logic st;
        st = idex_is_load && (live(idex_we, idex_rd, id_rs1_vld, id_rs1) ||
                              live(idex_we, idex_rd, id_rs2_vld, id_rs2));
        chk({"R1 fwd_a ", ctx}, fwd_a, ref_sel(ex_rs1_vld, ex_rs1));
        chk({"R2 fwd_b ", ctx}, fwd_b, ref_sel(ex_rs2_vld, ex_rs2));
        chk({"R8 pc_en ", ctx}, pc_en, !st);
        chk({"R8 ifid_en ", ctx}, ifid_en, !st);
        chk({"R7 bubble ", ctx}, bubble, st);
        chk({"R9 rf_byp_a ", ctx}, rf_byp_a, live(wb_we, wb_rd, id_rs1_vld, id_rs1));
        chk({"R9 rf_byp_b ", ctx}, rf_byp_b, live(wb_we, wb_rd, id_rs2_vld, id_rs2));
    endtask

    task automatic clear_in();
        {ex_rs1, ex_rs2, mem_rd, wb_rd, id_rs1, id_rs2, idex_rd} = '0;
        {ex_rs1_vld, ex_rs2_vld, mem_we, wb_we, id_rs1_vld, id_rs2_vld} = '0;
        {idex_is_load, idex_we} = '0;
    endtask

    // drive after the falling edge, sample before the next rising edge (R10: same cycle)
    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    initial begin
        clear_in();
        repeat (2) @(posedge clk);
        rst = 1'b0;
        settle();
        chk("R5 reset fwd_a", fwd_a, 0);
        chk("R8 reset pc_en", pc_en, 1);
        chk("R8 reset bubble", bubble, 0);

        // R3: writeback only
        ex_rs1 = 5'd7; ex_rs1_vld = 1; wb_we = 1; wb_rd = 5'd7;
        #1; chk("R3 wb only", fwd_a, 2);
        // R4: both stages match
        mem_we = 1; mem_rd = 5'd7;
        #1; chk("R4 both match", fwd_a, 1);
        // R4: memory stage writes another register -> writeback wins
        mem_rd = 5'd8;
        #1; chk("R3 mem other reg", fwd_a, 2);
        // R5: register 0
        clear_in(); ex_rs2 = 0; ex_rs2_vld = 1; mem_we = 1; mem_rd = 0;
        #1; chk("R5 reg zero", fwd_b, 0);
        // R6: masked source
        clear_in(); ex_rs2 = 5'd9; ex_rs2_vld = 0; mem_we = 1; mem_rd = 5'd9;
        #1; chk("R6 masked ex", fwd_b, 0);
        // R6 / R7: masked decode source vs load
        clear_in(); idex_is_load = 1; idex_we = 1; idex_rd = 5'd4; id_rs2 = 5'd4;
        #1; chk("R6 masked id stall", bubble, 0);
        id_rs2_vld = 1;
        #1; chk("R7 load use", bubble, 1);
        chk("R8 pc_en held", pc_en, 0);
        chk("R8 ifid_en held", ifid_en, 0);
        // R7: non-load does not stall
        idex_is_load = 0;
        #1; chk("R7 not load", bubble, 0);
        // R7: load to r0 does not stall
        idex_is_load = 1; idex_rd = 0; id_rs2 = 0;
        #1; chk("R7 load r0", bubble, 0);
        // R9
        clear_in(); wb_we = 1; wb_rd = 5'd12; id_rs1 = 5'd12; id_rs1_vld = 1;
        #1; chk("R9 rf pass", rf_byp_a, 1);
        chk("R9 rf other", rf_byp_b, 0);

        // randomised sweep over a narrow register range, compared every cycle
        for (int i = 0; i < 3000; i++) begin
            settle();
            ex_rs1 = 5'($urandom_range(0, 3)); ex_rs2 = 5'($urandom_range(0, 3));
            mem_rd = 5'($urandom_range(0, 3)); wb_rd  = 5'($urandom_range(0, 3));
            id_rs1 = 5'($urandom_range(0, 3)); id_rs2 = 5'($urandom_range(0, 3));
            idex_rd = 5'($urandom_range(0, 3));
            {ex_rs1_vld, ex_rs2_vld, mem_we, wb_we} = 4'($urandom);
            {id_rs1_vld, id_rs2_vld, idex_is_load, idex_we} = 4'($urandom);
            #1;
            compare_all("random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule